// File: doc/BRIEF.md
# DMA Page Address Generator

This block sits beside a pair of cascaded four-channel DMA controllers and turns each controller's 16-bit current address into a full 24-bit system memory address. A set of byte-wide page registers, one per usable channel plus one for memory refresh, is written and read through a small I/O port. For every transfer the controller reports which channel is active together with its 16-bit address. The block then combines that address with the matching page register and drives the memory address lines and the byte-high-enable signal.

Channels 0 to 3 move single bytes and channels 5 to 7 move 16-bit words. The two groups form the address in different ways. On a byte channel the page gives the top eight bits. On a word channel the controller address is shifted up by one position, and only the upper seven page bits are used. In neither group can the controller address carry into the page, so a transfer block wraps inside its 64K or 128K window. Channel 4 links the first controller to the second and never produces a memory address. The output is all combinational from the registered page values.

Top module: `dma_page_addr`

## Requirements
- R1: After reset every page register reads back as 0x00, so byte channels address page zero.
- R2: Each page register is written on the clock edge where io_wr is high, and read back on io_rdata while io_rd is high, at these I/O addresses: channel 0 at 0x87, channel 1 at 0x83, channel 2 at 0x81, channel 3 at 0x82, channel 5 at 0x8B, channel 6 at 0x89, channel 7 at 0x8A, refresh at 0x8F.
- R3: On channels 0 to 3, mem_addr[23:16] equals the channel's page register and mem_addr[15:0] equals ctl_addr.
- R4: On channels 0 to 3, bhe equals the inverse of mem_addr[0].
- R5: On channels 5 to 7, mem_addr[23:17] equals page bits 7 to 1 and mem_addr[16:1] equals ctl_addr. Page bit 0 has no effect.
- R6: On channels 5 to 7, mem_addr[0] and bhe are both 0.
- R7: A controller address of 0xFFFF never carries into the page bits. The page portion of mem_addr stays equal to the page register.
- R8: When chan is 4, addr_valid, mem_addr and bhe are all 0. For any other channel, addr_valid is 1.
- R9: A write to an I/O address outside the eight listed in R2 changes no register, and reading such an address gives 0x00. Writing the refresh register changes no channel's address.
- R10: A page write first affects mem_addr in the cycle after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data, 0 when not selected |
| chan | input | 3 | Active DMA channel number |
| ctl_addr | input | 16 | Current address from the channel controller |
| mem_addr | output | 24 | Memory address A23..A0 |
| bhe | output | 1 | Byte-high-enable |
| addr_valid | output | 1 | High when the channel produces a memory address |

## Verification
A vector table sets a page value and a controller address for every channel, including channel 4. The byte-channel entries mix odd and even low bits, so that the bhe polarity is seen in both states. The word-channel entries use page values with bit 0 set, which tells a correct seven-bit page apart from one that leaks bit 0 into the address. Entries with all-ones controller addresses and all-ones pages would expose any carry into the page or any slip in the shift.

Directed tests cover the following:
- Reset readback of every register.
- The write-to-output latency, sampled just before and just after the storing edge.
- Writes to an unmapped address.
- A refresh write, which must leave every channel's address as it was.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int NUM_SLOTS = 8;
   localparam int SLOT_W    = 3;
   localparam int CASCADE_CH = 4;

   // Slot 4 carries no channel page, so it holds the refresh page.
   localparam logic [7:0] PORT_CH0 = 8'h87;
   localparam logic [7:0] PORT_CH1 = 8'h83;
   localparam logic [7:0] PORT_CH2 = 8'h81;
   localparam logic [7:0] PORT_CH3 = 8'h82;
   localparam logic [7:0] PORT_RFS = 8'h8F;
   localparam logic [7:0] PORT_CH5 = 8'h8B;
   localparam logic [7:0] PORT_CH6 = 8'h89;
   localparam logic [7:0] PORT_CH7 = 8'h8A;

   typedef struct packed {
      logic              hit;
      logic [SLOT_W-1:0] slot;
   } slot_sel_t;

   function automatic slot_sel_t decode_port(input logic [7:0] a);
      slot_sel_t s;
      s.hit  = 1'b1;
      s.slot = '0;
      case (a)
         PORT_CH0: s.slot = 3'd0;
         PORT_CH1: s.slot = 3'd1;
         PORT_CH2: s.slot = 3'd2;
         PORT_CH3: s.slot = 3'd3;
         PORT_RFS: s.slot = 3'd4;
         PORT_CH5: s.slot = 3'd5;
         PORT_CH6: s.slot = 3'd6;
         PORT_CH7: s.slot = 3'd7;
         default:  s.hit  = 1'b0;
      endcase
      return s;
   endfunction

   function automatic logic is_word_chan(input logic [SLOT_W-1:0] c);
      return c[SLOT_W-1] && (c != SLOT_W'(CASCADE_CH));
   endfunction
endpackage

// File: rtl/dpa_page_regs.sv
module dpa_page_regs
   import dpa_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int IO_AW  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IO_AW-1:0]            io_addr,
   input  logic [PAGE_W-1:0]           io_wdata,
   input  logic                        io_wr,
   input  logic                        io_rd,
   output logic [PAGE_W-1:0]           io_rdata,
   output logic [NUM_SLOTS*PAGE_W-1:0] page_flat
);
   slot_sel_t sel;

   always_comb sel = decode_port(8'(io_addr));

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         logic [PAGE_W-1:0] page_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               page_q <= '0;
            else if (io_wr && sel.hit && (sel.slot == SLOT_W'(g)))
               page_q <= io_wdata;
         end
         assign page_flat[g*PAGE_W +: PAGE_W] = page_q;
      end
   endgenerate

   always_comb begin
      io_rdata = '0;
      if (io_rd && sel.hit)
         io_rdata = page_flat[int'(sel.slot)*PAGE_W +: PAGE_W];
   end
endmodule

// File: rtl/dpa_addr_map.sv
module dpa_addr_map
   import dpa_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int CTL_W  = 16,
   parameter int ADDR_W = 24
) (
   input  logic [SLOT_W-1:0]           chan,
   input  logic [CTL_W-1:0]            ctl_addr,
   input  logic [NUM_SLOTS*PAGE_W-1:0] page_flat,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic                        bhe,
   output logic                        addr_valid
);
   localparam int WPAGE_W = ADDR_W - CTL_W - 1;

   logic [PAGE_W-1:0] page_sel;
   logic [ADDR_W-1:0] byte_addr;
   logic [ADDR_W-1:0] word_addr;
   logic              cascade;

   always_comb page_sel = page_flat[int'(chan)*PAGE_W +: PAGE_W];
   always_comb cascade  = (chan == SLOT_W'(CASCADE_CH));

   generate
      if (WPAGE_W == PAGE_W - 1) begin : g_word_drop_lsb
         // Word page drops its lowest bit; controller bits land one place up.
         assign word_addr = {page_sel[PAGE_W-1:1], ctl_addr, 1'b0};
      end else begin : g_word_generic
         assign word_addr = {page_sel[PAGE_W-1 -: WPAGE_W], ctl_addr, 1'b0};
      end
   endgenerate

   // Concatenation, not addition: no carry may reach the page bits.
   assign byte_addr = {page_sel, ctl_addr};

   always_comb begin
      mem_addr   = '0;
      bhe        = 1'b0;
      addr_valid = 1'b0;
      if (!cascade) begin
         addr_valid = 1'b1;
         if (is_word_chan(chan)) begin
            mem_addr = word_addr;
         end else begin
            mem_addr = byte_addr;
            bhe      = ~byte_addr[0];
         end
      end
   end
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr #(
   parameter int PAGE_W = 8,
   parameter int CTL_W  = 16,
   parameter int ADDR_W = 24,
   parameter int IO_AW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic [PAGE_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [PAGE_W-1:0] io_rdata,
   input  logic [2:0]        chan,
   input  logic [CTL_W-1:0]  ctl_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              bhe,
   output logic              addr_valid
);
   localparam int FLAT_W = dpa_pkg::NUM_SLOTS * PAGE_W;

   generate
      if (ADDR_W != CTL_W + PAGE_W) begin : g_bad_width
         $error("ADDR_W must equal CTL_W + PAGE_W");
      end
      if (IO_AW != 8) begin : g_bad_io
         $error("IO_AW must be 8 for the fixed port map");
      end
   endgenerate

   logic [FLAT_W-1:0] page_flat;

   dpa_page_regs #(.PAGE_W(PAGE_W), .IO_AW(IO_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_rdata  (io_rdata),
      .page_flat (page_flat)
   );

   dpa_addr_map #(.PAGE_W(PAGE_W), .CTL_W(CTL_W), .ADDR_W(ADDR_W)) u_map (
      .chan       (chan),
      .ctl_addr   (ctl_addr),
      .page_flat  (page_flat),
      .mem_addr   (mem_addr),
      .bhe        (bhe),
      .addr_valid (addr_valid)
   );
endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
   parameter int CTL_W  = 16,
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [2:0]        chan,
   input logic [CTL_W-1:0]  ctl_addr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              bhe,
   input logic              addr_valid
);
   logic byte_ch, word_ch;
   assign byte_ch = !chan[2];
   assign word_ch = chan[2] && (chan != 3'd4);

   assert_cascade_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == 3'd4) |-> (!addr_valid && mem_addr == '0 && !bhe));

   assert_valid_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chan != 3'd4) |-> addr_valid);

   assert_byte_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ch |-> (mem_addr[CTL_W-1:0] == ctl_addr));

   assert_byte_bhe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ch |-> (bhe != mem_addr[0]));

   assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_ch |-> (!mem_addr[0] && !bhe));

   assert_word_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_ch |-> (mem_addr[CTL_W:1] == ctl_addr));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(io_wr) && $stable(chan) && $stable(ctl_addr)) |-> $stable(mem_addr));
endmodule

bind dma_page_addr dma_page_addr_chk #(.CTL_W(CTL_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_wr      (io_wr),
   .chan       (chan),
   .ctl_addr   (ctl_addr),
   .mem_addr   (mem_addr),
   .bhe        (bhe),
   .addr_valid (addr_valid)
);

// File: tb/dma_page_addr_bench.sv
module dma_page_addr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic [7:0]  io_wdata = 8'h00;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic [2:0]  chan = 3'd0;
   logic [15:0] ctl_addr = 16'h0000;
   logic [23:0] mem_addr;
   logic        bhe;
   logic        addr_valid;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dma_page_addr u_dma_page_addr (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .chan(chan),
      .ctl_addr(ctl_addr), .mem_addr(mem_addr), .bhe(bhe), .addr_valid(addr_valid)
   );

   // {chan, page, ctl, expected addr, expected bhe, expected valid}
   localparam logic [52:0] VEC [8] = '{
      {3'd0, 8'h12, 16'h3456, 24'h123456, 1'b1, 1'b1},
      {3'd1, 8'hA5, 16'hFFFF, 24'hA5FFFF, 1'b0, 1'b1},
      {3'd2, 8'hFF, 16'h0001, 24'hFF0001, 1'b0, 1'b1},
      {3'd3, 8'h00, 16'h8000, 24'h008000, 1'b1, 1'b1},
      {3'd5, 8'h13, 16'h1234, 24'h122468, 1'b0, 1'b1},
      {3'd6, 8'hFF, 16'hFFFF, 24'hFFFFFE, 1'b0, 1'b1},
      {3'd7, 8'h81, 16'h8001, 24'h810002, 1'b0, 1'b1},
      {3'd4, 8'h77, 16'h1234, 24'h000000, 1'b0, 1'b0}
   };

   function automatic logic [7:0] port_of(input logic [2:0] c);
      case (c)
         3'd0: return 8'h87;
         3'd1: return 8'h83;
         3'd2: return 8'h81;
         3'd3: return 8'h82;
         3'd4: return 8'h8F;
         3'd5: return 8'h8B;
         3'd6: return 8'h89;
         default: return 8'h8A;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      #1;
   endtask

   task automatic io_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values on every mapped register
      for (int c = 0; c < 8; c++) begin
         io_read(port_of(3'(c)), rd);
         check("R1 reset readback", 32'(rd), 32'h0);
      end
      @(negedge clk); chan = 3'd2; ctl_addr = 16'hBEEF; #1;
      check("R1 reset address", 32'(mem_addr), 32'h00BEEF);

      // Vector table: R2..R8
      for (int i = 0; i < 8; i++) begin
         logic [2:0] vc; logic [7:0] vp; logic [15:0] va;
         logic [23:0] ea; logic eb; logic ev;
         {vc, vp, va, ea, eb, ev} = VEC[i];
         io_write(port_of(vc), vp);
         io_read(port_of(vc), rd);
         check("R2 readback", 32'(rd), 32'(vp));
         @(negedge clk); chan = vc; ctl_addr = va; #1;
         check("R3/R5/R7 mem_addr", 32'(mem_addr), 32'(ea));
         check("R4/R6 bhe", 32'(bhe), 32'(eb));
         check("R8 addr_valid", 32'(addr_valid), 32'(ev));
      end

      // R5: page bit 0 ignored on word channels
      io_write(8'h89, 8'hFE);
      @(negedge clk); chan = 3'd6; ctl_addr = 16'hFFFF; #1;
      check("R5 page bit0 ignored", 32'(mem_addr), 32'hFFFFFE);

      // R9: unmapped write and read
      io_write(8'h84, 8'h5A);
      io_read(8'h84, rd);
      check("R9 unmapped read", 32'(rd), 32'h0);
      @(negedge clk); chan = 3'd0; ctl_addr = 16'h3456; #1;
      check("R9 unmapped write no effect", 32'(mem_addr), 32'h123456);

      // R9: refresh write leaves channel 3 address unchanged
      io_write(8'h8F, 8'hC3);
      @(negedge clk); chan = 3'd3; ctl_addr = 16'h8000; #1;
      check("R9 refresh isolated", 32'(mem_addr), 32'h008000);
      io_read(8'h8F, rd);
      check("R2 refresh readback", 32'(rd), 32'hC3);

      // R10: latency of a page write
      @(negedge clk); chan = 3'd1; ctl_addr = 16'h0010;
      io_addr = 8'h83; io_wdata = 8'h3C; io_wr = 1'b1; #1;
      check("R10 before edge", 32'(mem_addr), 32'hA50010);
      @(negedge clk); io_wr = 1'b0; #1;
      check("R10 after edge", 32'(mem_addr), 32'h3C0010);

      // R8: cascade again with non-zero address
      @(negedge clk); chan = 3'd4; ctl_addr = 16'hFFFF; #1;
      check("R8 cascade addr", 32'(mem_addr), 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule